// File: doc/BRIEF.md
# Hex-ASCII Serial Word Transmitter

This block turns a binary data word into one human-readable line on an asynchronous serial output. A single-cycle load strobe hands it a 16-bit word. The block then sends that word as four uppercase hexadecimal ASCII characters, most significant nibble first. A newline byte and then a carriage return byte close the line. Each character uses 8N1 framing: one start bit, eight data bits, one stop bit, and no parity.

The bit clock comes from an internal divider. The divider is set by a clock-frequency parameter and a baud-rate parameter, so the same code serves 100 MHz at 115200 baud (the default) or 9600 baud. A sampling source can drive the load strobe directly from its data-valid pulse. While a line is being sent, the block raises a busy flag and ignores further strobes. The word is held in an internal register, so the source may change its output at once.

Top module: `hex_line_tx`

## Requirements
- R1: An accepted word produces exactly six characters, in this order: hex digits for bits [15:12], [11:8], [7:4] and [3:0], then 0x0A, then 0x0D.
- R2: A nibble of 0 to 9 is sent as byte 0x30 to 0x39. A nibble of 10 to 15 is sent as byte 0x41 to 0x46 (uppercase).
- R3: Each character is framed as a low start bit, then eight data bits with bit 0 first, then a high stop bit. The line is high whenever the block is not busy.
- R4: Every bit lasts exactly CLK_HZ/BAUD_RATE clock cycles. The divider counts 0 to CLK_HZ/BAUD_RATE-1, wraps to zero and issues a one-cycle tick on the wrap.
- R5: The serial line changes only in the cycle after a bit tick. The first start bit begins within CLK_HZ/BAUD_RATE+1 cycles of the accepted strobe.
- R6: The six characters of one line are sent back to back. The next start bit follows a stop bit with no idle time.
- R7: Busy goes high in the cycle after an accepted strobe. It stays high until the carriage return's stop bit has lasted one full bit time, and then falls.
- R8: A load strobe that arrives while busy is high has no effect. No extra characters are sent, and the line in progress is unchanged.
- R9: The word is captured on the accepted strobe. Later changes on the data input do not alter the characters sent.
- R10: After a synchronous reset the line is high and busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| word_i | input | 16 | Data word to send |
| load_i | input | 1 | One-cycle strobe; accepted only when not busy |
| busy_o | output | 1 | High while a line is being sent |
| txd_o | output | 1 | Serial output, idles high |

## Verification
The embedded assertions check several rules on every cycle:
- the divider never passes its terminal count, and it ticks only on the wrap;
- the line only moves right after a tick, and it rests high while idle;
- an accepted strobe always raises busy;
- a strobe during busy leaves the captured word untouched;
- the reset state is correct.

Other properties need whole frames and only the bench's scenarios can show them: the decoded character order, the hex mapping at both nibble extremes, bit-exact timing, the absence of gaps between characters, the length of the busy window, and immunity to input changes after capture.

// File: rtl/hexline_pkg.sv
package hexline_pkg;

    // Bits per character: start, eight data, stop.
    localparam int unsigned FRAME_BITS = 10;
    localparam int unsigned POS_W      = 4;

    localparam logic [7:0] CHAR_NEWLINE = 8'h0A;
    localparam logic [7:0] CHAR_RETURN  = 8'h0D;
    localparam logic [7:0] DIGIT_BASE   = 8'h30;
    localparam logic [7:0] LETTER_BASE  = 8'h37;   // 'A' - 10

    // Register set of the baud divider.
    typedef struct packed {
        logic [31:0] cnt;
        logic        tick;
    } div_state_t;

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import hexline_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned BAUD_RATE = 115_200
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int unsigned DIV = (CLK_HZ / BAUD_RATE > 1) ? CLK_HZ / BAUD_RATE : 2;
    localparam logic [31:0] LAST = 32'(DIV - 1);

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 32'd1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R4
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LAST);
    // R4
    tick_on_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.tick |-> st_q.cnt == 32'd0);

endmodule

// File: rtl/hex_char_sel.sv
module hex_char_sel
    import hexline_pkg::*;
#(
    parameter int unsigned NIBBLES = 4,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [4*NIBBLES-1:0] word_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [7:0]           char_o
);
    logic [3:0] nib;

    always_comb begin
        nib = '0;
        for (int n = 0; n < NIBBLES; n++) begin
            if (int'(idx_i) == n) nib = word_i[4*(NIBBLES-1-n) +: 4];
        end
        if (int'(idx_i) < NIBBLES) begin
            if (nib < 4'd10) char_o = DIGIT_BASE  + {4'd0, nib};
            else             char_o = LETTER_BASE + {4'd0, nib};
        end else if (int'(idx_i) == NIBBLES) begin
            char_o = CHAR_NEWLINE;
        end else begin
            char_o = CHAR_RETURN;
        end
    end

endmodule

// File: rtl/frame_bit_sel.sv
module frame_bit_sel
    import hexline_pkg::*;
(
    input  logic [7:0]       char_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o
);
    always_comb begin
        if (pos_i == '0)                          bit_o = 1'b0;
        else if (pos_i <= POS_W'(FRAME_BITS - 2)) bit_o = char_i[3'(pos_i - POS_W'(1))];
        else                                      bit_o = 1'b1;
    end

endmodule

// File: rtl/hex_line_tx.sv
module hex_line_tx
    import hexline_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned BAUD_RATE = 115_200
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [15:0] word_i,
    input  logic        load_i,
    output logic        busy_o,
    output logic        txd_o
);
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned NIBBLES   = WORD_W / 4;
    localparam int unsigned LINE_LEN  = NIBBLES + 2;
    localparam int unsigned IDX_W     = $clog2(LINE_LEN);
    localparam logic [IDX_W-1:0] LAST_CHAR = IDX_W'(LINE_LEN - 1);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic              active;
        logic              fin;
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  chr;
        logic [POS_W-1:0]  pos;
        logic              line;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       tick;
    logic [7:0] cur_char;
    logic       cur_bit;

    baud_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD_RATE(BAUD_RATE)) u_div (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    hex_char_sel #(.NIBBLES(NIBBLES), .IDX_W(IDX_W)) u_chr (
        .word_i(st_q.word),
        .idx_i (st_q.chr),
        .char_o(cur_char)
    );

    frame_bit_sel u_bit (
        .char_i(cur_char),
        .pos_i (st_q.pos),
        .bit_o (cur_bit)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (load_i) begin
                st_d.active = 1'b1;
                st_d.fin    = 1'b0;
                st_d.word   = word_i;
                st_d.chr    = '0;
                st_d.pos    = '0;
            end
        end else if (tick) begin
            if (st_q.fin) begin
                st_d.active = 1'b0;
            end else begin
                st_d.line = cur_bit;
                if (st_q.pos == LAST_POS) begin
                    st_d.pos = '0;
                    if (st_q.chr == LAST_CHAR) st_d.fin = 1'b1;
                    else                       st_d.chr = st_q.chr + IDX_W'(1);
                end else begin
                    st_d.pos = st_q.pos + POS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.active;
    assign txd_o  = st_q.line;

    // R10
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (txd_o && !busy_o));
    // R3
    idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> txd_o);
    // R5
    line_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(txd_o) |-> $past(tick));
    // R7
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && !busy_o) |=> busy_o);
    // R8
    ignore_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && busy_o) |=> $stable(st_q.word));

endmodule

// File: tb/hex_line_tx_tb_top.sv
module hex_line_tx_tb_top;
    localparam int unsigned CLK_HZ = 1_600_000;
    localparam int unsigned BAUD   = 200_000;
    localparam int unsigned DIV    = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] word = '0;
    logic        load = 1'b0;
    logic        busy;
    logic        txd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hex_line_tx #(.CLK_HZ(CLK_HZ), .BAUD_RATE(BAUD)) dut_i (
        .clk_i (clk),
        .rst_i (rst),
        .word_i(word),
        .load_i(load),
        .busy_o(busy),
        .txd_o (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hex_of(input logic [3:0] n);
        return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + (n - 10));
    endfunction

    int strobe_cyc;

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        while (busy) @(negedge clk);
        word = w;
        load = 1'b1;
        strobe_cyc = cyc;
        @(negedge clk);
        load = 1'b0;
        word = ~w;  // R9: input changes after capture
        check(busy === 1'b1, "R7 busy after strobe", busy, 1);
        for (int k = 3; k >= 0; k--) exp_q.push_back(hex_of(w[4*k +: 4]));
        exp_q.push_back(8'h0A);
        exp_q.push_back(8'h0D);
    endtask

    task automatic wait_done();
        int dur;
        while (busy) @(negedge clk);
        dur = cyc - strobe_cyc;
        check(dur >= 60*DIV && dur <= 61*DIV + 2, "R7 busy window", dur, 60*DIV);
        check(txd === 1'b1, "R3 idle high", txd, 1);
    endtask

    // Monitor: decodes frames and compares them with the scoreboard queue.
    int line_pos = 0;
    initial begin
        logic [7:0] got;
        int gap;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            gap = 0;
            @(negedge clk);
            while (txd !== 1'b0) begin @(negedge clk); gap++; end
            if (line_pos != 0)
                check(gap == DIV/2 - 1, "R6 no gap between chars", gap, DIV/2 - 1);
            else
                check(cyc - strobe_cyc <= DIV + 2, "R5 first start latency", cyc - strobe_cyc, DIV);
            repeat (DIV/2) @(negedge clk);
            check(txd === 1'b0, "R3 start bit", txd, 0);
            for (int b = 0; b < 8; b++) begin
                repeat (DIV) @(negedge clk);
                got[b] = txd;
            end
            repeat (DIV) @(negedge clk);
            check(txd === 1'b1, "R3 stop bit", txd, 1);
            if (line_pos == 5) check(busy === 1'b1, "R7 busy through CR stop", busy, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected char", got, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got == e, "R1/R2 char value", got, e);
            end
            line_pos = (line_pos + 1) % 6;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(txd === 1'b1, "R10 reset line", txd, 1);
        check(busy === 1'b0, "R10 reset busy", busy, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R10 after reset", {busy, txd}, 1);

        send_word(16'h1234); wait_done();          // R1 digit order
        send_word(16'h0000); wait_done();          // R2 low digit edge
        send_word(16'hFFFF); wait_done();          // R2 high letter edge
        send_word(16'h9AC3); wait_done();          // R2 9/A boundary
        send_word(16'hA5C3);                       // R8: strobe during busy
        repeat (20*DIV) @(negedge clk);
        word = 16'h7777; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_done();
        send_word(16'h9C36); wait_done();          // R9 input toggled after capture
        send_word(16'hBEEF);                       // back-to-back lines
        wait_done();
        repeat (4*DIV) @(negedge clk);
        check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
        check(txd === 1'b1, "R3 final idle", txd, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule